// File: doc/BRIEF.md
# Transmit Output Routing Controller

This block is the digital control for the transmit analog output of a low-rate modem. Two asynchronous control levels come in: a filter-enable level and a mode-enable level. The block brings both into the master clock domain and decodes them into a one-hot source select for the analog output multiplexer. It also drives an active-high power-down line for the transmit low-pass filter. The four selectable sources are the filtered modulator signal, the filtered voice input, a test path from the receive band-pass filter, and the signal-ground bias.

The filter needs time to settle after it powers up. So when filter-enable goes from low to high, the select is held on signal ground for a fixed number of master clock cycles. The filter itself is powered from the first cycle of that interval. The default length is 44237 cycles of the 3.6864 MHz master clock, which is about 12 ms. If filter-enable drops during the interval, the interval is abandoned at once. The next rise then starts a full interval again. Analog switches, filter and output amplifier sit outside this block.

Top module: `txr_route_ctrl`

## Requirements
- R1: While the synchronous active-low reset is applied, the select reads ground (`src_sel_o` = 4'b1000) and `filt_pdn_o` = 1.
- R2: With filter-enable high and settled and mode-enable high, the select is the filtered modulator signal (bit 0, 4'b0001) and `filt_pdn_o` = 0.
- R3: With filter-enable high and settled and mode-enable low, the select is the filtered voice input (bit 1, 4'b0010) and `filt_pdn_o` = 0.
- R4: With filter-enable low and mode-enable high, the select is the receive-filter test path (bit 2, 4'b0100) and `filt_pdn_o` = 1.
- R5: With both controls low, the select is ground (bit 3, 4'b1000) and `filt_pdn_o` = 1.
- R6: `filt_pdn_o` is the inverse of the synchronised filter-enable. The filter is powered throughout the settling interval.
- R7: After a low-to-high change of filter-enable, the select stays on ground for exactly HOLD_CYCLES clock cycles, whatever mode-enable does, and then moves to the source that R2 or R3 names.
- R8: A drop of filter-enable during the settling interval returns the outputs to the R4/R5 state with the normal latency. The next rise waits a full HOLD_CYCLES again.
- R9: A change on either control input reaches the outputs on the third rising clock edge after it is set up: two synchroniser flops and one output register.
- R10: `src_sel_o` always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| filt_en_i | input | 1 | Filter-enable control level, asynchronous |
| mode_en_i | input | 1 | Mode-enable control level (1 = modulator, 0 = voice), asynchronous |
| src_sel_o | output | 4 | One-hot source select: bit0 modulator, bit1 voice, bit2 test, bit3 ground |
| filt_pdn_o | output | 1 | Transmit filter power-down, active high |

## Verification
The bench applies long steady levels of each of the four control combinations, so each decoded source and power-down value can be told apart after settling. It toggles mode-enable inside and outside the settling interval. This separates the forced-ground hold from a plain decode of the two levels. Filter-enable pulses shorter than, equal to and longer than the interval show an exact hold length and a clean restart after an abort. They also catch a hold that is off by one. Random level changes with a fixed seed mix all of these, and every cycle is compared with a model that counts three edges of latency.

// File: rtl/txr_pkg.sv
// Package: shared encodings for the transmit output routing controller.
// Assumes one-hot select lines, one per analog source.
package txr_pkg;
    localparam int unsigned SRC_COUNT = 4;

    // Bit positions of the one-hot select vector.
    localparam int unsigned SRC_MSK   = 0;
    localparam int unsigned SRC_VOICE = 1;
    localparam int unsigned SRC_TEST  = 2;
    localparam int unsigned SRC_GND   = 3;

    typedef logic [SRC_COUNT-1:0] src_sel_t;

    localparam src_sel_t SEL_MSK   = src_sel_t'(1) << SRC_MSK;
    localparam src_sel_t SEL_VOICE = src_sel_t'(1) << SRC_VOICE;
    localparam src_sel_t SEL_TEST  = src_sel_t'(1) << SRC_TEST;
    localparam src_sel_t SEL_GND   = src_sel_t'(1) << SRC_GND;
endpackage

// File: rtl/txr_sync.sv
// Module: multi-stage level synchroniser for a bundle of control bits.
// Assumes inputs are slow levels; each bit is synchronised independently.
module txr_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop: captures the raw asynchronous level.
                always_ff @(posedge clk_i) begin
                    if (!rst_ni) stage_q[0] <= '0;
                    else         stage_q[0] <= async_i;
                end
            end else begin : g_next
                // Later flops: let any metastability resolve.
                always_ff @(posedge clk_i) begin
                    if (!rst_ni) stage_q[s] <= '0;
                    else         stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/txr_settle_timer.sv
// Module: settling timer. Mutes the output for HOLD_CYCLES cycles after the
// synchronised filter-enable rises, and clears at once when it falls.
// Assumes filt_s_i is already in the clock domain.
module txr_settle_timer #(
    parameter int unsigned HOLD_CYCLES = 44237,
    localparam int unsigned CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic filt_s_i,
    output logic mute_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    // Counts enabled cycles until the hold is complete; a low level clears it.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !filt_s_i) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (cnt_q == LAST) done_q <= 1'b1;
            else               cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign mute_o = filt_s_i && !done_q;

    assert_abort_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !filt_s_i |=> (cnt_q == '0 && !done_q));
    assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);
    assert_hold_length_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_q) |-> $past(cnt_q) == LAST);
endmodule

// File: rtl/txr_route_decode.sv
// Module: combinational decode of the two control levels and the mute flag
// into a one-hot source select and a filter power-down.
// Assumes all inputs are synchronous to the same clock.
module txr_route_decode
    import txr_pkg::*;
(
    input  logic     filt_s_i,
    input  logic     mode_s_i,
    input  logic     mute_i,
    output src_sel_t sel_o,
    output logic     pdn_o
);
    // Picks the output source for the present control state.
    always_comb begin
        pdn_o = !filt_s_i;
        if (!filt_s_i)  sel_o = mode_s_i ? SEL_TEST : SEL_GND;
        else if (mute_i) sel_o = SEL_GND;
        else            sel_o = mode_s_i ? SEL_MSK : SEL_VOICE;
    end
endmodule

// File: rtl/txr_route_ctrl.sv
// Module: top of the transmit output routing controller. Synchronises the
// controls, runs the settling timer, decodes, and registers the outputs.
// Assumes a free-running master clock and a synchronous active-low reset.
module txr_route_ctrl
    import txr_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 44237,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       filt_en_i,
    input  logic       mode_en_i,
    output logic [3:0] src_sel_o,
    output logic       filt_pdn_o
);
    logic [1:0] ctl_s;
    logic       mute;
    src_sel_t   sel_d;
    logic       pdn_d;

    txr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({mode_en_i, filt_en_i}),
        .sync_o  (ctl_s)
    );

    txr_settle_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .filt_s_i (ctl_s[0]),
        .mute_o   (mute)
    );

    txr_route_decode u_decode (
        .filt_s_i (ctl_s[0]),
        .mode_s_i (ctl_s[1]),
        .mute_i   (mute),
        .sel_o    (sel_d),
        .pdn_o    (pdn_d)
    );

    // Output register: glitch-free drive of the analog switch controls.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            src_sel_o  <= SEL_GND;
            filt_pdn_o <= 1'b1;
        end else begin
            src_sel_o  <= sel_d;
            filt_pdn_o <= pdn_d;
        end
    end

    assert_onehot_sel_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot(src_sel_o));
    assert_filtered_powered_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_sel_o[SRC_MSK] || src_sel_o[SRC_VOICE]) |-> !filt_pdn_o);
    assert_down_routes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        filt_pdn_o |-> (src_sel_o[SRC_TEST] || src_sel_o[SRC_GND]));
    assert_test_powered_down_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        src_sel_o[SRC_TEST] |-> filt_pdn_o);
endmodule

// File: tb/txr_route_ctrl_tb.sv
// Bench: cycle-accurate reference model with three-edge latency, fed by
// directed corner cases and seeded random level changes.
module txr_route_ctrl_tb_top;
    localparam int HOLD = 40;
    localparam int LIMIT = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       filt = 1'b0;
    logic       mode = 1'b0;
    logic [3:0] sel;
    logic       pdn;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit ended = 0;
    string phase = "";

    // applied-input history: index 0 newest, 2 oldest
    int h_f [3];
    int h_m [3];
    int h_r [3];

    txr_route_ctrl #(.HOLD_CYCLES(HOLD)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .filt_en_i(filt), .mode_en_i(mode),
        .src_sel_o(sel), .filt_pdn_o(pdn)
    );

    always #10 clk = ~clk;

    function automatic logic [3:0] exp_sel(int f, int m, int r);
        if (f == 0) return (m != 0) ? 4'b0100 : 4'b1000; // R4 / R5
        if (r <= HOLD) return 4'b1000;                    // R7 hold
        return (m != 0) ? 4'b0001 : 4'b0010;              // R2 / R3
    endfunction

    function automatic string req_of(int f, int m, int r);
        if (f == 0) return (m != 0) ? "R4" : "R5";
        if (r <= HOLD) return "R7";
        return (m != 0) ? "R2" : "R3";
    endfunction

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s%s: got %b expected %b at cycle %0d", req, phase, act, exp, cycles);
        end
    endtask

    task automatic clear_hist();
        for (int i = 0; i < 3; i++) begin h_f[i] = 0; h_m[i] = 0; h_r[i] = 0; end
    endtask

    // One cycle: sample at negedge against the model, then drive new levels.
    task automatic step(int f, int m);
        @(negedge clk);
        cycles++;
        if (!rst_n) begin
            check("R1", sel, 4'b1000);
            check("R1", {3'b0, pdn}, 4'b0001);
        end else begin
            check(req_of(h_f[2], h_m[2], h_r[2]), sel, exp_sel(h_f[2], h_m[2], h_r[2]));
            check("R6", {3'b0, pdn}, {3'b0, (h_f[2] == 0)});
            check("R10", {3'b0, ($countones(sel) == 1)}, 4'b0001);
        end
        filt = f[0];
        mode = m[0];
        if (rst_n) begin
            h_f[2] = h_f[1]; h_m[2] = h_m[1]; h_r[2] = h_r[1];
            h_f[1] = h_f[0]; h_m[1] = h_m[0]; h_r[1] = h_r[0];
            h_r[0] = (f != 0) ? ((h_r[0] > HOLD) ? HOLD + 1 : h_r[0] + 1) : 0;
            h_f[0] = f; h_m[0] = m;
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_hist();
        // R1: reset state, with inputs high to show reset dominates
        rst_n = 1'b0;
        step(0, 0); step(0, 0);
        filt = 1'b1; mode = 1'b1;
        step(1, 1); step(1, 1);
        filt = 1'b0; mode = 1'b0;
        step(0, 0);
        @(negedge clk); rst_n = 1'b1; clear_hist(); filt = 0; mode = 0;

        // R5 then R4 steady
        repeat (6) step(0, 0);
        repeat (6) step(0, 1);
        // R9: latency of mode change observed by the model's three-edge delay
        phase = " R9";
        step(0, 0); step(0, 1); step(0, 0); step(0, 0); step(0, 0);
        phase = "";
        // R7 with R2: full hold, mode toggling inside the hold
        for (int i = 0; i < HOLD + 10; i++) step(1, (i % 3 == 0) ? 0 : 1);
        repeat (8) step(1, 1);
        // R3 steady
        repeat (8) step(1, 0);
        // R8: abort mid-hold, then full restart; also off-by-one pulses
        phase = " R8";
        repeat (4) step(0, 1);
        repeat (HOLD / 2) step(1, 1);
        repeat (3) step(0, 1);
        repeat (HOLD + 6) step(1, 1);
        repeat (3) step(0, 0);
        repeat (HOLD - 1) step(1, 0);
        repeat (3) step(0, 0);
        repeat (HOLD) step(1, 0);
        repeat (3) step(0, 0);
        repeat (HOLD + 1) step(1, 0);
        repeat (4) step(0, 0);
        step(1, 1); repeat (4) step(0, 1);
        phase = "";
        // Random level changes
        begin
            int f = 0;
            int m = 0;
            for (int i = 0; i < 4000; i++) begin
                if ($urandom_range(0, 29) == 0) f = 1 - f;
                if ($urandom_range(0, 7) == 0) m = 1 - m;
                step(f, m);
            end
        end
        repeat (4) step(0, 0);
        finish_run();
    end
endmodule